// File: doc/BRIEF.md
# Branch Resolution and Redirect Unit

This block settles the outcome of control-flow instructions in a 64-bit in-order core whose execute path has two stages. It takes a branch class from the decoder, the current instruction address, the 32-bit instruction word, the count, link, target-address and saved-return-address register values, one condition bit, and the fetch stage's taken prediction. Two clock edges later it reports whether fetch must be redirected and where. It also reports the decremented count value to write back, the link value to write, and the return address a system call must save.

All branch targets come from a single adder. For relative forms the adder's first input is the current address. For absolute forms that input is zero. For register branches and interrupt return, the second input is the selected register value. A second small incrementer in the later stage produces the fall-through address (current + 4). That address serves mispredicted not-taken branches, instruction-sync, the link write and the system-call save.

Top module: `branch_resolve_unit`

## Requirements
- R1: `class_i` codes are 0 none, 1 unconditional, 2 conditional, 3 through-register, 4 interrupt return, 5 instruction-sync, 6 system call. An input is accepted only in a cycle with `valid_i` high. Its results appear on the outputs after the second rising clock edge and hold for exactly one cycle. With `valid_i` low, no output write or redirect is produced.
- R2: The unconditional target uses the offset `insn_i[25:2]`, shifted left by 2 and sign-extended. It is added to `cia_i` when the absolute bit `insn_i[1]` is 0, and used alone when that bit is 1.
- R3: The conditional target uses the offset `insn_i[15:2]`, shifted left by 2 and sign-extended, with the same `insn_i[1]` rule as R2.
- R4: A through-register branch takes LR when `insn_i[10]` is 0. When `insn_i[10]` is 1 it takes CTR if `insn_i[6]` is 0 and TAR if `insn_i[6]` is 1.
- R5: CTR is decremented (`ctr_we_o` high, `ctr_wdata_o` = `ctr_i` - 1) for a conditional or through-register branch whose `insn_i[23]` is 0. A branch that takes its target from CTR never decrements.
- R6: Unconditional branches are always taken. The other branch classes need two tests to pass. The count test is skipped unless a decrement happens; otherwise the decremented value must be zero when `insn_i[22]` is 1 and nonzero when it is 0. The condition test is skipped when `insn_i[25]` is 1; otherwise `cr_bit_i` must equal `insn_i[24]`.
- R7: A taken branch that was predicted not taken redirects to its target. A not-taken branch that was predicted taken redirects to `cia_i` + 4. A correctly predicted branch does not redirect.
- R8: Instruction-sync always redirects to `cia_i` + 4.
- R9: Interrupt return always redirects to `srr0_i`.
- R10: A system call does not redirect; it raises `save_we_o` with `save_addr_o` = `cia_i` + 4.
- R11: A branch of class 1, 2 or 3 with link bit `insn_i[0]` set raises `lr_we_o` with `lr_wdata_o` = `cia_i` + 4.
- R12: Every redirect address has its two low bits forced to zero.
- R13: While `rst_ni` is low, and right after it rises, all write-enable and redirect outputs are zero, even if an instruction was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| class_i | input | 3 | Branch class code |
| cia_i | input | XLEN | Current instruction address |
| insn_i | input | 32 | Instruction word |
| ctr_i | input | XLEN | Count register value |
| lr_i | input | XLEN | Link register value |
| tar_i | input | XLEN | Target-address register value |
| srr0_i | input | XLEN | Saved return address for interrupt return |
| cr_bit_i | input | 1 | Selected condition bit |
| pred_taken_i | input | 1 | Fetch predicted this branch taken |
| redir_valid_o | output | 1 | Redirect fetch this cycle |
| redir_addr_o | output | XLEN | Redirect address |
| ctr_we_o | output | 1 | Count register write |
| ctr_wdata_o | output | XLEN | Decremented count value |
| lr_we_o | output | 1 | Link register write |
| lr_wdata_o | output | XLEN | Link value |
| save_we_o | output | 1 | System-call return address write |
| save_addr_o | output | XLEN | System-call return address |

## Verification
The bench builds the block with the default XLEN of 64. At that width a small negative offset must sign-extend across the full upper half of the address. Absolute negative targets land at the very top of the address space, and relative negative offsets must borrow through the current address. Small count values of one and two reach the boundary where the decremented count hits zero, under both zero-test polarities. A saved return address with its low bits set shows the alignment of redirect addresses.

// File: rtl/brnc_pkg.sv
package brnc_pkg;

  typedef enum logic [2:0] {
    BC_NONE    = 3'd0,
    BC_UNCOND  = 3'd1,
    BC_COND    = 3'd2,
    BC_REG     = 3'd3,
    BC_RFI     = 3'd4,
    BC_ISYNC   = 3'd5,
    BC_SYSCALL = 3'd6
  } br_class_e;

  typedef enum logic [2:0] {
    SRC_LI   = 3'd0,
    SRC_BD   = 3'd1,
    SRC_LR   = 3'd2,
    SRC_CTR  = 3'd3,
    SRC_TAR  = 3'd4,
    SRC_SRR0 = 3'd5
  } tgt_src_e;

  typedef struct packed {
    logic     branch;
    logic     uncond;
    logic     rel;
    logic     link;
    logic     dec_ctr;
    logic     isync;
    logic     rfi;
    logic     sc;
    tgt_src_e src;
  } br_ctl_t;

endpackage

// File: rtl/brnc_decode.sv
module brnc_decode
  import brnc_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] class_i,
  input  logic       aa_i,
  input  logic       lk_i,
  input  logic       skip_ctr_i,
  input  logic       sel_hi_i,
  input  logic       sel_lo_i,
  output br_ctl_t    ctl_o
);

  br_class_e cls;
  assign cls = br_class_e'(class_i);

  always_comb begin
    ctl_o     = '0;
    ctl_o.src = SRC_LI;
    if (valid_i) begin
      case (cls)
        BC_UNCOND: begin
          ctl_o.branch = 1'b1;
          ctl_o.uncond = 1'b1;
          ctl_o.rel    = ~aa_i;
          ctl_o.link   = lk_i;
          ctl_o.src    = SRC_LI;
        end
        BC_COND: begin
          ctl_o.branch  = 1'b1;
          ctl_o.rel     = ~aa_i;
          ctl_o.link    = lk_i;
          ctl_o.dec_ctr = ~skip_ctr_i;
          ctl_o.src     = SRC_BD;
        end
        BC_REG: begin
          ctl_o.branch  = 1'b1;
          ctl_o.link    = lk_i;
          // a branch through CTR must not also count it down
          ctl_o.dec_ctr = ~skip_ctr_i & ~(sel_hi_i & ~sel_lo_i);
          if (!sel_hi_i)     ctl_o.src = SRC_LR;
          else if (!sel_lo_i) ctl_o.src = SRC_CTR;
          else               ctl_o.src = SRC_TAR;
        end
        BC_RFI: begin
          ctl_o.rfi = 1'b1;
          ctl_o.src = SRC_SRR0;
        end
        BC_ISYNC:   ctl_o.isync = 1'b1;
        BC_SYSCALL: ctl_o.sc    = 1'b1;
        default:    ctl_o       = '0;
      endcase
    end
  end

endmodule

// File: rtl/brnc_target.sv
module brnc_target
  import brnc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            rel_i,
  input  tgt_src_e        src_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [23:0]     li_i,
  input  logic [13:0]     bd_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] tar_i,
  input  logic [XLEN-1:0] srr0_i,
  output logic [XLEN-1:0] tgt_o
);

  localparam int LI_W = 24;
  localparam int BD_W = 14;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic [XLEN-1:0] opnd, base, sum;

  always_comb begin
    case (src_i)
      SRC_LI:   opnd = {{(XLEN-LI_W-2){li_i[LI_W-1]}}, li_i, 2'b00};
      SRC_BD:   opnd = {{(XLEN-BD_W-2){bd_i[BD_W-1]}}, bd_i, 2'b00};
      SRC_LR:   opnd = lr_i;
      SRC_CTR:  opnd = ctr_i;
      SRC_TAR:  opnd = tar_i;
      SRC_SRR0: opnd = srr0_i;
      default:  opnd = '0;
    endcase
  end

  // single shared adder; A leg is the current address only for relative forms
  assign base  = rel_i ? cia_i : '0;
  assign sum   = base + opnd;
  assign tgt_o = sum & ALIGN_MASK;

endmodule

// File: rtl/brnc_cond.sv
module brnc_cond #(
  parameter int XLEN = 64
) (
  input  logic            uncond_i,
  input  logic            dec_i,
  input  logic [3:0]      bo_i,      // [3] skip cond, [2] expected, [1] skip ctr, [0] on zero
  input  logic            cr_bit_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic            taken_o,
  output logic [XLEN-1:0] ctr_dec_o
);

  logic ctr_zero, ctr_ok, cr_ok;

  assign ctr_dec_o = ctr_i - XLEN'(1);
  assign ctr_zero  = (ctr_dec_o == '0);
  assign ctr_ok    = bo_i[1] | ~dec_i | (ctr_zero == bo_i[0]);
  assign cr_ok     = bo_i[3] | (cr_bit_i == bo_i[2]);
  assign taken_o   = uncond_i | (ctr_ok & cr_ok);

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brnc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      class_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] tar_i,
  input  logic [XLEN-1:0] srr0_i,
  input  logic            cr_bit_i,
  input  logic            pred_taken_i,
  output logic            redir_valid_o,
  output logic [XLEN-1:0] redir_addr_o,
  output logic            ctr_we_o,
  output logic [XLEN-1:0] ctr_wdata_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_wdata_o,
  output logic            save_we_o,
  output logic [XLEN-1:0] save_addr_o
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  br_ctl_t         ctl;
  logic [XLEN-1:0] tgt, ctr_dec;
  logic            taken;
  logic            unused_opcode;

  assign unused_opcode = ^{insn_i[31:26], insn_i[20:16]};

  brnc_decode u_dec (
    .valid_i    (valid_i),
    .class_i    (class_i),
    .aa_i       (insn_i[1]),
    .lk_i       (insn_i[0]),
    .skip_ctr_i (insn_i[23]),
    .sel_hi_i   (insn_i[10]),
    .sel_lo_i   (insn_i[6]),
    .ctl_o      (ctl)
  );

  brnc_target #(.XLEN(XLEN)) u_tgt (
    .rel_i  (ctl.rel),
    .src_i  (ctl.src),
    .cia_i  (cia_i),
    .li_i   (insn_i[25:2]),
    .bd_i   (insn_i[15:2]),
    .lr_i   (lr_i),
    .ctr_i  (ctr_i),
    .tar_i  (tar_i),
    .srr0_i (srr0_i),
    .tgt_o  (tgt)
  );

  brnc_cond #(.XLEN(XLEN)) u_cond (
    .uncond_i  (ctl.uncond),
    .dec_i     (ctl.dec_ctr),
    .bo_i      (insn_i[25:22]),
    .cr_bit_i  (cr_bit_i),
    .ctr_i     (ctr_i),
    .taken_o   (taken),
    .ctr_dec_o (ctr_dec)
  );

  // stage 1: resolved outcome and target
  logic            s1_br, s1_taken, s1_pred, s1_link, s1_dec, s1_isync, s1_rfi, s1_sc;
  logic [XLEN-1:0] s1_tgt, s1_cia, s1_ctr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_br    <= 1'b0;
      s1_taken <= 1'b0;
      s1_pred  <= 1'b0;
      s1_link  <= 1'b0;
      s1_dec   <= 1'b0;
      s1_isync <= 1'b0;
      s1_rfi   <= 1'b0;
      s1_sc    <= 1'b0;
      s1_tgt   <= '0;
      s1_cia   <= '0;
      s1_ctr   <= '0;
    end else begin
      s1_br    <= ctl.branch;
      s1_taken <= taken;
      s1_pred  <= pred_taken_i;
      s1_link  <= ctl.link;
      s1_dec   <= ctl.dec_ctr;
      s1_isync <= ctl.isync;
      s1_rfi   <= ctl.rfi;
      s1_sc    <= ctl.sc;
      s1_tgt   <= tgt;
      s1_cia   <= cia_i;
      s1_ctr   <= ctr_dec;
    end
  end

  // stage 2: fall-through address and redirect choice
  logic [XLEN-1:0] next_nia, redir_addr;
  logic            redir_need, use_tgt;

  assign next_nia   = s1_cia + INSN_BYTES;
  assign redir_need = s1_rfi | s1_isync | (s1_br & (s1_taken ^ s1_pred));
  assign use_tgt    = s1_rfi | (s1_br & s1_taken);
  assign redir_addr = use_tgt ? s1_tgt : (next_nia & ALIGN_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o <= 1'b0;
      redir_addr_o  <= '0;
      ctr_we_o      <= 1'b0;
      ctr_wdata_o   <= '0;
      lr_we_o       <= 1'b0;
      lr_wdata_o    <= '0;
      save_we_o     <= 1'b0;
      save_addr_o   <= '0;
    end else begin
      redir_valid_o <= redir_need;
      redir_addr_o  <= redir_addr;
      ctr_we_o      <= s1_dec;
      ctr_wdata_o   <= s1_ctr;
      lr_we_o       <= s1_link;
      lr_wdata_o    <= next_nia;
      save_we_o     <= s1_sc;
      save_addr_o   <= next_nia;
    end
  end

endmodule

// File: rtl/brnc_chk.sv
module brnc_chk
  import brnc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      class_i,
  input logic [XLEN-1:0] cia_i,
  input logic [XLEN-1:0] ctr_i,
  input logic            via_ctr_i,
  input logic            redir_valid_o,
  input logic [XLEN-1:0] redir_addr_o,
  input logic            ctr_we_o,
  input logic [XLEN-1:0] ctr_wdata_o,
  input logic            lr_we_o,
  input logic [XLEN-1:0] lr_wdata_o,
  input logic            save_we_o
);

  localparam logic [XLEN-1:0] FOUR = XLEN'(4);
  localparam logic [XLEN-1:0] MASK = ~XLEN'(3);

  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  // R1
  redir_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && redir_valid_o) |-> $past(valid_i, 2));

  // R5
  ctr_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && ctr_we_o) |-> (ctr_wdata_o == $past(ctr_i, 2) - XLEN'(1)));

  // R5
  ctr_branch_no_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i, 2) && $past(class_i, 2) == BC_REG && $past(via_ctr_i, 2))
    |-> !ctr_we_o);

  // R8
  isync_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i, 2) && $past(class_i, 2) == BC_ISYNC)
    |-> (redir_valid_o && redir_addr_o == (($past(cia_i, 2) + FOUR) & MASK)));

  // R10
  syscall_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i, 2) && $past(class_i, 2) == BC_SYSCALL)
    |-> (save_we_o && !redir_valid_o));

  // R11
  link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && lr_we_o) |-> (lr_wdata_o == $past(cia_i, 2) + FOUR));

  // R12
  redir_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o |-> (redir_addr_o[1:0] == 2'b00));

endmodule

bind branch_resolve_unit brnc_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .class_i       (class_i),
  .cia_i         (cia_i),
  .ctr_i         (ctr_i),
  .via_ctr_i     (insn_i[10] & ~insn_i[6]),
  .redir_valid_o (redir_valid_o),
  .redir_addr_o  (redir_addr_o),
  .ctr_we_o      (ctr_we_o),
  .ctr_wdata_o   (ctr_wdata_o),
  .lr_we_o       (lr_we_o),
  .lr_wdata_o    (lr_wdata_o),
  .save_we_o     (save_we_o)
);

// File: tb/sim_branch_resolve_unit.sv
module sim_branch_resolve_unit;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 64;
  localparam int WDOG_LIMIT = 20000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [2:0]      class_i = '0;
  logic [XLEN-1:0] cia_i = '0;
  logic [31:0]     insn_i = '0;
  logic [XLEN-1:0] ctr_i = '0, lr_i = '0, tar_i = '0, srr0_i = '0;
  logic            cr_bit_i = 1'b0, pred_taken_i = 1'b0;
  logic            redir_valid_o, ctr_we_o, lr_we_o, save_we_o;
  logic [XLEN-1:0] redir_addr_o, ctr_wdata_o, lr_wdata_o, save_addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolve_unit #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .class_i(class_i),
    .cia_i(cia_i), .insn_i(insn_i), .ctr_i(ctr_i), .lr_i(lr_i), .tar_i(tar_i),
    .srr0_i(srr0_i), .cr_bit_i(cr_bit_i), .pred_taken_i(pred_taken_i),
    .redir_valid_o(redir_valid_o), .redir_addr_o(redir_addr_o),
    .ctr_we_o(ctr_we_o), .ctr_wdata_o(ctr_wdata_o),
    .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o),
    .save_we_o(save_we_o), .save_addr_o(save_addr_o)
  );

  function automatic logic [31:0] mk_b(input logic [23:0] li, input logic aa, input logic lk);
    return {6'd18, li, aa, lk};
  endfunction

  function automatic logic [31:0] mk_bc(input logic [4:0] bo, input logic [13:0] bd,
                                        input logic aa, input logic lk);
    return {6'd16, bo, 5'd0, bd, aa, lk};
  endfunction

  function automatic logic [31:0] mk_br(input logic [4:0] bo, input logic b10,
                                        input logic b6, input logic lk);
    return {6'd19, bo, 5'd0, 5'd0, b10, 3'b000, b6, 5'd0, lk};
  endfunction

  typedef struct packed {
    logic [2:0]  cls;
    logic [63:0] cia;
    logic [31:0] insn;
    logic [63:0] ctr;
    logic [63:0] lr;
    logic [63:0] tar;
    logic [63:0] srr0;
    logic        crb;
    logic        pred;
    logic        rv;
    logic [63:0] ra;
    logic        cwe;
    logic [63:0] cw;
    logic        lwe;
    logic        sv;
  } vec_t;

  localparam int NV = 18;
  localparam logic [63:0] C = 64'h1000;
  localparam logic [63:0] Z = 64'h0;

  localparam vec_t VECS [NV] = '{
    // R2 relative forward, R11 link, R7 predicted not taken
    '{3'd1, C, mk_b(24'd16, 1'b0, 1'b1), Z, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h1040, 1'b0, Z, 1'b1, 1'b0},
    // R2 absolute negative
    '{3'd1, C, mk_b(24'hFFFFFC, 1'b1, 1'b0), Z, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, Z, 1'b0, 1'b0},
    // R2 relative backward
    '{3'd1, C, mk_b(24'hFFFFFC, 1'b0, 1'b0), Z, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h0FF0, 1'b0, Z, 1'b0, 1'b0},
    // R7 correct taken prediction
    '{3'd1, C, mk_b(24'hFFFFFC, 1'b0, 1'b0), Z, Z, Z, Z, 1'b0, 1'b1, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0},
    // R3 conditional always-taken relative
    '{3'd2, C, mk_bc(5'b10100, 14'd8, 1'b0, 1'b0), Z, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h1020, 1'b0, Z, 1'b0, 1'b0},
    // R6 cond fails, R7 predicted taken -> fall through
    '{3'd2, C, mk_bc(5'b01100, 14'd8, 1'b0, 1'b0), Z, Z, Z, Z, 1'b0, 1'b1, 1'b1, 64'h1004, 1'b0, Z, 1'b0, 1'b0},
    // R3 absolute negative, R6 cond passes
    '{3'd2, C, mk_bc(5'b01100, 14'h3FFF, 1'b1, 1'b0), Z, Z, Z, Z, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, Z, 1'b0, 1'b0},
    // R5 decrement to nonzero, R6 taken, R7 correct prediction
    '{3'd2, C, mk_bc(5'b10000, 14'd8, 1'b0, 1'b0), 64'd5, Z, Z, Z, 1'b0, 1'b1, 1'b0, Z, 1'b1, 64'd4, 1'b0, 1'b0},
    // R5 decrement to zero, R6 not taken, R7 fall through
    '{3'd2, C, mk_bc(5'b10000, 14'd8, 1'b0, 1'b0), 64'd1, Z, Z, Z, 1'b0, 1'b1, 1'b1, 64'h1004, 1'b1, 64'd0, 1'b0, 1'b0},
    // R6 branch on zero
    '{3'd2, C, mk_bc(5'b10010, 14'd4, 1'b0, 1'b0), 64'd1, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h1010, 1'b1, 64'd0, 1'b0, 1'b0},
    // R4 via LR, R12 low bits cleared, R11 link
    '{3'd3, C, mk_br(5'b10100, 1'b0, 1'b0, 1'b1), Z, 64'h2003, Z, Z, 1'b0, 1'b0, 1'b1, 64'h2000, 1'b0, Z, 1'b1, 1'b0},
    // R4 via CTR, R5 no decrement
    '{3'd3, C, mk_br(5'b10000, 1'b1, 1'b0, 1'b0), 64'h3000, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h3000, 1'b0, Z, 1'b0, 1'b0},
    // R4 via TAR, R5 decrement, R6 both tests
    '{3'd3, C, mk_br(5'b00000, 1'b1, 1'b1, 1'b0), 64'd2, Z, 64'h4000, Z, 1'b0, 1'b0, 1'b1, 64'h4000, 1'b1, 64'd1, 1'b0, 1'b0},
    // R9 interrupt return, R12
    '{3'd4, C, 32'd0, Z, Z, Z, 64'h5006, 1'b0, 1'b1, 1'b1, 64'h5004, 1'b0, Z, 1'b0, 1'b0},
    // R8 instruction-sync
    '{3'd5, C, 32'd0, Z, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h1004, 1'b0, Z, 1'b0, 1'b0},
    // R10 system call
    '{3'd6, C, 32'd0, Z, Z, Z, Z, 1'b0, 1'b1, 1'b0, Z, 1'b0, Z, 1'b0, 1'b1},
    // R1 class none
    '{3'd0, C, mk_b(24'd16, 1'b0, 1'b1), Z, Z, Z, Z, 1'b0, 1'b1, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0},
    // R2 relative crossing, R11 link from other address
    '{3'd1, 64'h7FF0, mk_b(24'd4, 1'b0, 1'b1), Z, Z, Z, Z, 1'b0, 1'b0, 1'b1, 64'h8000, 1'b0, Z, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    valid_i      = vld;
    class_i      = v.cls;
    cia_i        = v.cia;
    insn_i       = v.insn;
    ctr_i        = v.ctr;
    lr_i         = v.lr;
    tar_i        = v.tar;
    srr0_i       = v.srr0;
    cr_bit_i     = v.crb;
    pred_taken_i = v.pred;
  endtask

  task automatic expect_vec(input vec_t v, input string tag);
    check(redir_valid_o == v.rv, {tag, " redirect valid"}, 64'(redir_valid_o), 64'(v.rv));
    if (v.rv) check(redir_addr_o == v.ra, {tag, " redirect addr"}, redir_addr_o, v.ra);
    check(ctr_we_o == v.cwe, {tag, " R5 ctr we"}, 64'(ctr_we_o), 64'(v.cwe));
    if (v.cwe) check(ctr_wdata_o == v.cw, {tag, " R5 ctr data"}, ctr_wdata_o, v.cw);
    check(lr_we_o == v.lwe, {tag, " R11 lr we"}, 64'(lr_we_o), 64'(v.lwe));
    if (v.lwe) check(lr_wdata_o == v.cia + 64'd4, {tag, " R11 lr data"}, lr_wdata_o, v.cia + 64'd4);
    check(save_we_o == v.sv, {tag, " R10 save we"}, 64'(save_we_o), 64'(v.sv));
    if (v.sv) check(save_addr_o == v.cia + 64'd4, {tag, " R10 save addr"}, save_addr_o, v.cia + 64'd4);
  endtask

  task automatic all_quiet(input string tag);
    check(!redir_valid_o && !ctr_we_o && !lr_we_o && !save_we_o, tag,
          64'({redir_valid_o, ctr_we_o, lr_we_o, save_we_o}), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    all_quiet("R13 reset held");
    rst_ni = 1'b1;
    @(negedge clk);
    all_quiet("R13 after release");

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      valid_i = 1'b0;
      @(negedge clk);
      expect_vec(VECS[i], $sformatf("vec%0d", i));
    end

    // R1 pulse lasts a single cycle
    drive(VECS[0], 1'b1);
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    check(redir_valid_o == 1'b1, "R1 pulse start", 64'(redir_valid_o), 64'd1);
    @(negedge clk);
    all_quiet("R1 pulse ends");

    // R1 R8 back-to-back instruction-sync
    v = VECS[14];
    drive(v, 1'b1);
    @(negedge clk);
    v.cia = 64'h2000;
    drive(v, 1'b1);
    @(negedge clk);
    valid_i = 1'b0;
    check(redir_valid_o && redir_addr_o == 64'h1004, "R8 first isync", redir_addr_o, 64'h1004);
    @(negedge clk);
    check(redir_valid_o && redir_addr_o == 64'h2004, "R8 second isync", redir_addr_o, 64'h2004);
    @(negedge clk);
    all_quiet("R1 after back-to-back");

    // R1 inputs ignored while valid low
    drive(VECS[14], 1'b0);
    @(negedge clk);
    @(negedge clk);
    all_quiet("R1 isync without valid");
    drive(VECS[7], 1'b0);
    @(negedge clk);
    @(negedge clk);
    all_quiet("R1 ctr branch without valid");

    // R13 reset with an instruction in flight
    drive(VECS[14], 1'b1);
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk);
    all_quiet("R13 in-flight reset");
    rst_ni = 1'b1;
    @(negedge clk);
    all_quiet("R13 after in-flight reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule